// File: doc/BRIEF.md
# Selectable Prescaler With Input Debounce

This block serves one counter/timer channel. A 3-bit rate code sets the rate of a one-cycle enable pulse, which the counter uses as its count strobe when it runs from the internal clock. The same code sets the length of a debounce window on the channel's raw input. The filter is never gated by the clock-source choice, so the counter sees a clean input whether it counts internal strobes or edges of an external input.

A free-running base counter divides the system clock by `BASE_DIV` to give the fastest rate (code 0). A 7-bit binary divider behind it provides the slower rates. Code k picks divider stage k. The debounce window is a fixed table of microsecond units per code, scaled by `US_CYC`, the number of system cycles in one microsecond. Both parameters can be kept small so that a simulation stays short.

Top module: `rate_debounce_gen`

## Requirements
- R1: With rate code k (binary 0..7) held, `tick_o` pulses once every `BASE_DIV * 2^k` clock cycles. Code 0 is the fastest rate and each higher code halves it.
- R2: Each `tick_o` pulse is exactly one clock cycle wide.
- R3: A new rate code is taken into use only at the divider wrap point, which comes every `128 * BASE_DIV` cycles. Ticks keep the old spacing until then. Every gap between ticks across a code change equals either the old period or the new period, so no runt interval occurs.
- R4: The debounce window is `US_CYC * W` cycles, with W = 2, 4, 8, 15, 31, 61, 120, 250 for codes 0..7. The window is taken from `rate_sel_i` directly. When `raw_i` moves to a new level and stays there, `clean_o` takes that level exactly W*US_CYC + 2 clock edges after the first edge that samples the new level. The two extra edges are the synchroniser.
- R5: A pulse on `raw_i` that lasts fewer clock cycles than the window leaves `clean_o` unchanged. Any return to the old level restarts the stability count from zero.
- R6: `raw_i` passes through a two-stage synchroniser before the filter. The filter runs in every cycle, independent of `tick_o`.
- R7: While `rst_ni` is low, `tick_o` and `clean_o` are low and the dividers are cleared. After release with code k held, the first tick is high in the cycle that follows clock edge number `BASE_DIV * 2^k - 1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_sel_i | input | 3 | Rate code: sets the tick rate and the debounce window |
| raw_i | input | 1 | Unsynchronised channel input |
| tick_o | output | 1 | One-cycle count enable for the internal clock source |
| clean_o | output | 1 | Debounced, synchronised channel input |

## Verification
Every rate code is held long enough to pass a wrap point, and the spacing of three successive ticks is then compared with its power-of-two period. A mixed-up stage select or an off-by-one stage shows up there as a wrong gap. A code change made just after a tick, going from a fast to a slow code, checks that each gap is either the old or the new period. A select that switches at once would produce an in-between gap. For the input filter, clean steps at several codes separate the window lengths and the synchroniser delay exactly. A pulse one cycle short of the window, and a broken high level followed by a held one, show that the count needs unbroken stability and restarts after any glitch.

// File: rtl/rdb_pkg.sv
package rdb_pkg;
  localparam int SEL_W = 3;
  localparam int NCODE = 1 << SEL_W;
  localparam int DIV_W = NCODE - 1;
  localparam int MAX_UNITS = 250;

  // debounce window in microsecond units, per rate code
  function automatic int unsigned db_units(logic [SEL_W-1:0] code);
    case (code)
      3'd0: db_units = 2;
      3'd1: db_units = 4;
      3'd2: db_units = 8;
      3'd3: db_units = 15;
      3'd4: db_units = 31;
      3'd5: db_units = 61;
      3'd6: db_units = 120;
      default: db_units = 250;
    endcase
  endfunction
endpackage

// File: rtl/rdb_prescaler.sv
module rdb_prescaler
  import rdb_pkg::*;
#(
  parameter int BASE_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int BW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
  localparam logic [BW-1:0] BLAST = BW'(BASE_DIV - 1);

  logic [BW-1:0]    bcnt_q;
  logic [DIV_W-1:0] div_q;
  logic [SEL_W-1:0] sel_q;
  logic             run_q;
  logic             base_stb, wrap;
  logic [NCODE-1:0] hit;

  assign base_stb = (bcnt_q == BLAST);
  assign wrap     = base_stb && (&div_q);

  // stage k fires when the low k divider bits are all ones
  assign hit[0] = 1'b1;
  for (genvar g = 1; g < NCODE; g++) begin : g_stage
    assign hit[g] = &div_q[g-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcnt_q <= '0;
      div_q  <= '0;
      sel_q  <= '0;
      run_q  <= 1'b0;
    end else begin
      bcnt_q <= base_stb ? '0 : bcnt_q + 1'b1;
      if (base_stb) begin
        div_q <= div_q + 1'b1;
        run_q <= 1'b1;
      end
      // code only switches at a full divider boundary
      if (!run_q || wrap) sel_q <= sel_i;
    end
  end

  assign tick_o = base_stb && hit[sel_q];
endmodule

// File: rtl/rdb_sync.sv
module rdb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/rdb_debounce.sv
module rdb_debounce
  import rdb_pkg::*;
#(
  parameter int US_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             d_i,
  output logic             q_o
);
  localparam int CW = $clog2(MAX_UNITS * US_CYC + 1) + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          q_q;

  assign lim = CW'(US_CYC * db_units(sel_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
    end else if (d_i == q_q) begin
      cnt_q <= '0;
    end else if (cnt_q + 1'b1 >= lim) begin
      // >= keeps a window shortened mid-count from stalling
      q_q   <= d_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/rate_debounce_gen.sv
module rate_debounce_gen
  import rdb_pkg::*;
#(
  parameter int BASE_DIV = 4,
  parameter int US_CYC   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] rate_sel_i,
  input  logic             raw_i,
  output logic             tick_o,
  output logic             clean_o
);
  logic raw_s;

  rdb_prescaler #(.BASE_DIV(BASE_DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (rate_sel_i),
    .tick_o (tick_o)
  );

  rdb_sync #(.STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_i),
    .q_o    (raw_s)
  );

  rdb_debounce #(.US_CYC(US_CYC)) u_db (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (rate_sel_i),
    .d_i    (raw_s),
    .q_o    (clean_o)
  );
endmodule

// File: rtl/rdb_checker.sv
module rdb_checker
  import rdb_pkg::*;
#(
  parameter int BASE_DIV = 4,
  parameter int US_CYC   = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SEL_W-1:0] rate_sel_i,
  input logic             raw_i,
  input logic             tick_o,
  input logic             clean_o
);
  int unsigned gap_q, stab_q, lim_q;
  logic        seen_q, raw_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q      <= 0;
      seen_q     <= 1'b0;
      stab_q     <= 0;
      raw_prev_q <= 1'b0;
      lim_q      <= 0;
    end else begin
      gap_q      <= tick_o ? 1 : ((gap_q < 32'hFFFF_0000) ? gap_q + 1 : gap_q);
      seen_q     <= seen_q | tick_o;
      raw_prev_q <= raw_i;
      stab_q     <= (raw_i != raw_prev_q) ? 0 :
                    ((stab_q < 32'hFFFF_0000) ? stab_q + 1 : stab_q);
      lim_q      <= US_CYC * db_units(rate_sel_i);
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!tick_o && !clean_o)); // R7

  AST_TICK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R2

  AST_TICK_GRID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && seen_q) |-> (gap_q >= BASE_DIV && (gap_q % BASE_DIV) == 0)); // R1

  AST_CLEAN_FOLLOWS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(clean_o) |-> (clean_o == $past(raw_i, 3))); // R6

  AST_CLEAN_NEEDS_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(clean_o) |-> ($past(stab_q, 2) + 1 >= lim_q)); // R5
endmodule

bind rate_debounce_gen rdb_checker #(.BASE_DIV(BASE_DIV), .US_CYC(US_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rate_sel_i (rate_sel_i),
  .raw_i      (raw_i),
  .tick_o     (tick_o),
  .clean_o    (clean_o)
);

// File: tb/sim_rate_debounce_gen.sv
module sim_rate_debounce_gen;
  localparam int B  = 4;
  localparam int US = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       raw = 1'b0;
  logic       tick, clean;

  int n_run = 0;
  int n_fail = 0;
  int exp_q[$];
  int gap = 0;
  bit prev_tick = 1'b0;
  bit trans = 1'b0;
  int p_old = 0, p_new = 0;
  int trans_seen = 0;

  always #4 clk = ~clk;

  rate_debounce_gen #(.BASE_DIV(B), .US_CYC(US)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rate_sel_i(sel),
    .raw_i(raw), .tick_o(tick), .clean_o(clean)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int win(int k);
    case (k)
      0: win = 2;   1: win = 4;   2: win = 8;   3: win = 15;
      4: win = 31;  5: win = 61;  6: win = 120; default: win = 250;
    endcase
    win = win * US;
  endfunction

  // monitor: pops expected tick gaps and compares
  always @(negedge clk) begin
    if (rst_n) begin
      gap++;
      if (tick) begin
        if (exp_q.size() > 0) begin
          int e;
          e = exp_q.pop_front();
          chk(gap == e, "R1 tick gap", gap, e);
        end else if (trans) begin
          trans_seen++;
          chk(gap == p_old || gap == p_new, "R3 gap across code change", gap, p_new);
        end
        if (prev_tick) chk(1'b0, "R2 tick width", 2, 1);
        gap = 0;
      end
      prev_tick = tick;
    end
  end

  task automatic sync_tick();
    do @(negedge clk); while (!tick);
    @(posedge clk);
  endtask

  task automatic db_step(bit lvl, int exp_n);
    int n = 0;
    @(negedge clk);
    raw = lvl;
    do begin
      @(negedge clk);
      n++;
    end while (clean != lvl && n < exp_n + 20);
    chk(n == exp_n, "R4 debounce latency", n, exp_n);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    sel = 3'd2;
    repeat (3) @(negedge clk);
    chk(tick == 1'b0, "R7 tick low in reset", tick, 0);
    chk(clean == 1'b0, "R7 clean low in reset", clean, 0);
    rst_n = 1'b1;
    begin
      int n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (!tick && n < 100);
      chk(n == 4 * B - 1, "R7 first tick after reset", n, 4 * B - 1);
    end

    // R1 R2: every code
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      sel = 3'(k);
      repeat (128 * B + 20) @(negedge clk);
      sync_tick();
      @(negedge clk);
      chk(tick == 1'b0, "R2 tick cleared next cycle", tick, 0);
      for (int i = 0; i < 3; i++) exp_q.push_back(B << k);
      while (exp_q.size() > 0) @(negedge clk);
    end

    // R3: fast to slow change just after a tick
    @(negedge clk);
    sel = 3'd2;
    repeat (128 * B + 20) @(negedge clk);
    p_old = B << 2;
    p_new = B << 5;
    sync_tick();
    trans = 1'b1;
    @(negedge clk);
    sel = 3'd5;
    repeat (2 * 128 * B) @(negedge clk);
    trans = 1'b0;
    chk(trans_seen > 2, "R3 ticks observed across change", trans_seen, 3);

    // R4 R6: window per code, rise and fall
    for (int k = 0; k < 8; k += 3) begin
      @(negedge clk);
      sel = 3'(k);
      repeat (4) @(negedge clk);
      db_step(1'b1, win(k) + 2);
      db_step(1'b0, win(k) + 2);
    end

    // R5: short pulse ignored, broken level restarts count
    @(negedge clk);
    sel = 3'd1;
    repeat (4) @(negedge clk);
    raw = 1'b1;
    repeat (win(1) - 1) @(negedge clk);
    raw = 1'b0;
    repeat (win(1) + 10) @(negedge clk);
    chk(clean == 1'b0, "R5 short pulse ignored", clean, 0);
    raw = 1'b1;
    repeat (win(1) - 3) @(negedge clk);
    raw = 1'b0;
    db_step(1'b1, win(1) + 2);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule